// File: doc/BRIEF.md
# Status Flag Register and Conditional Branch Evaluator

This unit keeps the four processor status flags (negative, zero, overflow, carry) and decides, for a conditional branch instruction, whether the branch is taken. The arithmetic unit reports a new flag set through a one-cycle write strobe. The flags are registered and take effect at the next clock edge.

The instruction word is checked every cycle. A conditional branch is marked by one of two values in its top nibble. Its top six bits then select one of eight conditions. Its low ten bits give the branch target. The branch decision is combinational. It is made from the flags as they stand in the register. A flag write presented in the same cycle therefore affects only the following instructions.

Top module: `branch_cond_unit`

## Requirements
- R1: A synchronous active-high reset clears all four flags. `flags` reads 4'b0000 in the first cycle after reset is released.
- R2: When `upd_we` is high at a rising edge, `flags` takes the value of `upd_flags` from that edge onwards. The bit order is {N,Z,V,C} on bits 3..0.
- R3: When `upd_we` is low at a rising edge, `flags` keeps its value whatever `upd_flags` carries.
- R4: `is_branch` is high exactly when `instr_valid` is high and `instr[15:12]` is 4'b1000 or 4'b1111. The 6-bit condition code is `instr[15:10]`.
- R5: Code 6'o40 is taken when Z=1. Code 6'o41 is taken when Z=0.
- R6: Code 6'o42 is taken when N=0 and Z=0. Code 6'o43 is taken when N=0.
- R7: Code 6'o74 is taken when N=1. Code 6'o75 is taken when N=1 or Z=1.
- R8: Code 6'o76 is taken when C=1. Code 6'o77 is taken when C=0.
- R9: `target` always equals `instr[9:0]`, the address a taken branch loads into the program counter.
- R10: `take` is low whenever `is_branch` is low. This covers any other top nibble and any cycle with `instr_valid` low.
- R11: A branch presented together with a flag write is decided on the flags held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| upd_we | input | 1 | Flag write strobe from the arithmetic unit |
| upd_flags | input | 4 | New flags {N,Z,V,C} |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| flags | output | 4 | Stored flags {N,Z,V,C} |
| is_branch | output | 1 | Word is a conditional branch |
| take | output | 1 | Branch condition met |
| target | output | 10 | Branch target address |

## Verification
The hardest situation to reach is a branch that arrives in the same cycle as a flag write that would reverse its outcome. The bench drives a beq with a write that clears Z while Z is still set, and it expects the old outcome. The bench also loads each of the sixteen flag combinations through the write strobe. After each load it issues all eight condition codes with write disabled. This exercises every condition against every flag pattern, including the corners where N and Z are both set.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 10;
    localparam int CODE_W = 6;
    localparam int NIB_W  = 4;

    localparam logic [NIB_W-1:0] NIB_LOW_GRP  = 4'b1000;
    localparam logic [NIB_W-1:0] NIB_HIGH_GRP = 4'b1111;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef enum logic [2:0] {
        COND_EQ = 3'd0,
        COND_NE = 3'd1,
        COND_GT = 3'd2,
        COND_GE = 3'd3,
        COND_LT = 3'd4,
        COND_LE = 3'd5,
        COND_CS = 3'd6,
        COND_CC = 3'd7
    } cond_e;

    function automatic logic nib_is_branch(input logic [NIB_W-1:0] nib);
        return (nib == NIB_LOW_GRP) || (nib == NIB_HIGH_GRP);
    endfunction

    function automatic cond_e cond_of(input logic [CODE_W-1:0] code);
        logic hi;
        hi = (code[CODE_W-1 -: NIB_W] == NIB_HIGH_GRP);
        return cond_e'({hi, code[1:0]});
    endfunction

    function automatic logic cond_met(input cond_e c, input flags_t f);
        logic r;
        unique case (c)
            COND_EQ: r = f.z;
            COND_NE: r = !f.z;
            COND_GT: r = !f.n && !f.z;
            COND_GE: r = !f.n;
            COND_LT: r = f.n;
            COND_LE: r = f.n || f.z;
            COND_CS: r = f.c;
            COND_CC: r = !f.c;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bcu_flag_reg.sv
module bcu_flag_reg
    import bcu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   upd_we,
    input  flags_t upd_flags,
    output flags_t flags_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (upd_we) begin
            flags_q <= upd_flags;
        end
    end

    // R1: flags are clear once reset drops
    assert_flags_reset_R1: assert property (@(posedge clk)
        $fell(rst) |-> (flags_q == '0));

    // R2: a strobed write lands at the next edge
    assert_flags_load_R2: assert property (@(posedge clk) disable iff (rst)
        $past(upd_we) |-> (flags_q == $past(upd_flags)));

    // R3: without a strobe nothing moves
    assert_flags_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(upd_we) |-> $stable(flags_q));

endmodule

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
    import bcu_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int TGT_W  = ADDR_W
) (
    input  logic              instr_valid,
    input  logic [DATA_W-1:0] instr,
    input  flags_t            flags_cur,
    output logic              is_branch,
    output logic              take,
    output logic [TGT_W-1:0]  target
);

    localparam int CODE_LSB = DATA_W - CODE_W;

    logic [CODE_W-1:0] code;
    cond_e             cond;
    logic              met;

    always_comb begin
        code      = instr[DATA_W-1:CODE_LSB];
        cond      = cond_of(code);
        met       = cond_met(cond, flags_cur);
        is_branch = instr_valid && nib_is_branch(code[CODE_W-1 -: NIB_W]);
        take      = is_branch && met;
        target    = instr[TGT_W-1:0];
    end

endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
    import bcu_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int TGT_W  = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_we,
    input  logic [3:0]        upd_flags,
    input  logic              instr_valid,
    input  logic [DATA_W-1:0] instr,
    output logic [3:0]        flags,
    output logic              is_branch,
    output logic              take,
    output logic [TGT_W-1:0]  target
);

    flags_t flags_q;

    bcu_flag_reg u_flags (
        .clk       (clk),
        .rst       (rst),
        .upd_we    (upd_we),
        .upd_flags (flags_t'(upd_flags)),
        .flags_q   (flags_q)
    );

    bcu_cond_eval #(
        .DATA_W (DATA_W),
        .TGT_W  (TGT_W)
    ) u_eval (
        .instr_valid (instr_valid),
        .instr       (instr),
        .flags_cur   (flags_q),
        .is_branch   (is_branch),
        .take        (take),
        .target      (target)
    );

    assign flags = flags_q;

    // R10: a decision only ever accompanies a recognised branch
    assert_take_needs_branch_R10: assert property (@(posedge clk) disable iff (rst)
        take |-> is_branch);

    // R5: equal-branch follows the stored zero flag
    assert_beq_follows_z_R5: assert property (@(posedge clk) disable iff (rst)
        (is_branch && instr[DATA_W-1 -: CODE_W] == 6'o40) |-> (take == flags[2]));

    // R8: carry-set branch follows the stored carry flag
    assert_bcs_follows_c_R8: assert property (@(posedge clk) disable iff (rst)
        (is_branch && instr[DATA_W-1 -: CODE_W] == 6'o76) |-> (take == flags[0]));

    // R9: the target is the low field of the word
    assert_target_field_R9: assert property (@(posedge clk) disable iff (rst)
        target == instr[TGT_W-1:0]);

endmodule

// File: tb/branch_cond_unit_bench.sv
module branch_cond_unit_bench;

    localparam int PERIOD = 10;

    typedef struct {
        logic [3:0] fl;
        logic       isb;
        logic       tk;
        logic [9:0] tgt;
        string      req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        upd_we = 1'b0;
    logic [3:0]  upd_flags = 4'h0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = 16'h0;
    logic [3:0]  flags;
    logic        is_branch;
    logic        take;
    logic [9:0]  target;

    exp_t       q[$];
    logic [3:0] model_fl = 4'h0;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    branch_cond_unit u_branch_cond_unit (
        .clk         (clk),
        .rst         (rst),
        .upd_we      (upd_we),
        .upd_flags   (upd_flags),
        .instr_valid (instr_valid),
        .instr       (instr),
        .flags       (flags),
        .is_branch   (is_branch),
        .take        (take),
        .target      (target)
    );

    function automatic logic exp_cond(input logic [5:0] code, input logic [3:0] f);
        logic n, z, c;
        n = f[3]; z = f[2]; c = f[0];
        case (code)
            6'o40: return z;
            6'o41: return !z;
            6'o42: return !n && !z;
            6'o43: return !n;
            6'o74: return n;
            6'o75: return n || z;
            6'o76: return c;
            6'o77: return !c;
            default: return 1'b0;
        endcase
    endfunction

    task automatic drive(input logic we, input logic [3:0] f, input logic [15:0] ins,
                         input logic v, input string req);
        exp_t e;
        @(negedge clk);
        upd_we      = we;
        upd_flags   = f;
        instr       = ins;
        instr_valid = v;
        e.fl  = model_fl;
        e.isb = v && (ins[15:12] == 4'h8 || ins[15:12] == 4'hF);
        e.tk  = e.isb && exp_cond(ins[15:10], model_fl);
        e.tgt = ins[9:0];
        e.req = req;
        q.push_back(e);
        if (we) model_fl = f;
    endtask

    task automatic cmp(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            #(PERIOD/4);
            if (q.size() > 0) begin
                e = q.pop_front();
                cmp(e.req, "flags",     flags,     e.fl);
                cmp(e.req, "is_branch", is_branch, e.isb);
                cmp(e.req, "take",      take,      e.tk);
                cmp(e.req, "target",    target,    e.tgt);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin : watchdog
        #(PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: cleared flags after reset
        drive(1'b0, 4'h0, 16'h0000, 1'b1, "R1");

        for (int f = 0; f < 16; f++) begin
            // R2: load pattern through the strobe (R10 word is not a branch)
            drive(1'b1, 4'(f), 16'h1234, 1'b1, "R2");
            for (int k = 0; k < 8; k++) begin
                logic [5:0]  code;
                logic [9:0]  tg;
                string       rq;
                code = (k < 4) ? {4'b1000, 2'(k)} : {4'b1111, 2'(k)};
                tg   = 10'((f * 37 + k * 101) & 10'h3FF);
                case (k)
                    0, 1:    rq = "R5";
                    2, 3:    rq = "R6";
                    4, 5:    rq = "R7";
                    default: rq = "R8";
                endcase
                // R3 also: upd_flags toggles while upd_we is low
                drive(1'b0, ~4'(f), {code, tg}, 1'b1, rq);
            end
        end

        // R3: strobe low, junk on upd_flags, stored flags must not move
        drive(1'b0, 4'h0, 16'h0000, 1'b1, "R3");
        drive(1'b0, 4'h5, 16'h0000, 1'b1, "R3");

        // R4 / R10: other top nibbles are never branches
        for (int nb = 0; nb < 16; nb++) begin
            if (nb != 8 && nb != 15)
                drive(1'b0, 4'h0, {4'(nb), 2'b00, 10'h2AA}, 1'b1, "R4");
        end
        // R10: invalid word never takes
        drive(1'b0, 4'h0, {6'o40, 10'h155}, 1'b0, "R10");
        drive(1'b0, 4'h0, {6'o77, 10'h3FF}, 1'b0, "R10");

        // R9: extreme target values
        drive(1'b0, 4'h0, {6'o43, 10'h000}, 1'b1, "R9");
        drive(1'b0, 4'h0, {6'o74, 10'h3FF}, 1'b1, "R9");

        // R11: flags are all set here; write clears Z alongside a beq
        drive(1'b1, 4'h0, {6'o40, 10'h155}, 1'b1, "R11");
        drive(1'b0, 4'h0, {6'o40, 10'h155}, 1'b1, "R11");
        drive(1'b1, 4'h1, {6'o76, 10'h0AA}, 1'b1, "R11");
        drive(1'b0, 4'h0, {6'o76, 10'h0AA}, 1'b1, "R11");

        drive(1'b0, 4'h0, 16'h0000, 1'b0, "R3");
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule